// File: doc/BRIEF.md
# Four-Channel Interleaved Sample Ring Writer

This block paces a scanning analog-to-digital converter and stores its results in a circular sample memory. A tick divider produces one sample tick every `TICK_DIV` clock cycles. On each tick the block asks the converter for one result from each of the four inputs in turn: the supply voltage on channel 0 and the three current-transformer signals on channels 1 to 3. Each 12-bit result is written as a zero-extended 16-bit word through a synchronous RAM write port. The four words of one tick sit next to each other in memory, so entry `k` holds tick `k/4` and channel `k%4`.

The ring is split into two halves. When the last entry of the first half is written, a half event pulses. When the last entry of the ring is written, a full event pulses and the write pointer returns to zero. A consumer can then work on one half while the writer fills the other. At the default settings there are 1600 samples per channel and a 25 kHz tick rate, so each half covers 32 ms. Both events also set sticky flags that stay set until `clear` is pulsed. If an event fires while its flag is still set, a sticky lost-block flag is raised. A tick that arrives while a scan is still in progress raises a sticky overrun flag instead of starting a new scan.

The converter request and converter result are valid/ready streams. The request side holds `conv_req_valid` and `conv_req_ch` steady until the converter takes it, so the converter may stall for as long as it needs. The result side asserts `conv_res_ready` only while a result is awaited, and the converter holds its result until ready. The RAM port has no back-pressure: a write happens in the same cycle as the result handshake.

Top module: `adc_ring_writer`

## Requirements
- R1: While `enable` is high, the tick counter fires once every `TICK_DIV` cycles. The first tick comes `TICK_DIV` cycles after `enable` rises. A scan starts only on a tick seen while idle, and `conv_req_valid` rises in the cycle after that tick.
- R2: A scan requests channels in the order 0, 1, 2, 3. Each new request starts in the cycle after the previous result handshake. `conv_req_valid` and `conv_req_ch` hold steady until `conv_req_ready` is seen.
- R3: `conv_res_ready` is high only while a result is awaited. `mem_we` is high exactly in the cycles with a result handshake. `mem_wdata` is the 12-bit result in bits 11:0, and bits 15:12 are zero.
- R4: Each write goes to the current pointer, and the pointer then advances by one. Entries are interleaved as tick*4 + channel, starting from entry 0.
- R5: `half_evt` pulses together with the write to entry TOTAL/2-1. `full_evt` pulses together with the write to entry TOTAL-1, after which the pointer returns to 0.
- R6: `half_flag` and `full_flag` are set by their events and stay set until `clear` is high at a clock edge. An event in the same cycle as `clear` wins, so the flag stays set.
- R7: `lost_flag` is set when an event fires while its flag is already set and `clear` is low in that cycle. It is cleared only by `clear`.
- R8: A tick that arrives while a scan is in progress, including the cycle of the scan's last result handshake, sets the sticky `overrun_flag` and does not start a scan. `clear` resets this flag, with a set in the same cycle winning.
- R9: Dropping `enable` lets the current scan finish but starts no new one. Once idle, the pointer returns to 0, so the first write after `enable` returns goes to entry 0.
- R10: After reset all flags, events, `mem_we` and `conv_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Acquisition enable |
| clear | input | 1 | Clears all sticky flags |
| conv_req_valid | output | 1 | Conversion request valid |
| conv_req_ready | input | 1 | Converter accepts request |
| conv_req_ch | output | 2 | Channel to convert |
| conv_res_valid | input | 1 | Conversion result valid |
| conv_res_ready | output | 1 | Block accepts result |
| conv_res_data | input | 12 | Conversion result |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 13 | RAM write address |
| mem_wdata | output | 16 | RAM write data |
| half_evt | output | 1 | First half filled (pulse) |
| full_evt | output | 1 | Ring end reached (pulse) |
| half_flag | output | 1 | Sticky half event |
| full_flag | output | 1 | Sticky full event |
| lost_flag | output | 1 | Sticky: a block was overwritten unacknowledged |
| overrun_flag | output | 1 | Sticky: tick arrived during a scan |

## Verification
The bench uses a small ring so that it wraps many times. It checks the events at the half and full boundaries, where an off-by-one pointer would shift the pulse by one entry or skip entry 0 after a wrap.

The converter stalls on its request side, which catches a design that drops or changes its request before acceptance. A slow converter makes ticks land inside a scan and exactly on its last handshake; a design that restarted there would duplicate channels or miss the overrun flag.

Clearing the flags on the cycle their events fire shows whether the set-wins rule and the lost-block condition hold. Disabling in the middle of a scan shows whether the scan is cut short or whether the pointer is left where it stopped.

// File: rtl/adc_ring_pkg.sv
package adc_ring_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_WAIT = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int unsigned DIV = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);

  // R1: ticks are never back to back
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_ring_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned CH_W   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  output logic            req_valid,
  input  logic            req_ready,
  output logic [CH_W-1:0] req_ch,
  input  logic            res_valid,
  output logic            res_ready,
  output logic            wr_fire,
  output logic            busy,
  output logic            overrun_hit
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  seq_state_e     state;
  logic [CH_W-1:0] ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      ch    <= '0;
    end else begin
      unique case (state)
        SEQ_IDLE: if (tick) begin
          state <= SEQ_REQ;
          ch    <= '0;
        end
        SEQ_REQ: if (req_ready) state <= SEQ_WAIT;
        SEQ_WAIT: if (res_valid) begin
          if (ch == LAST_CH) state <= SEQ_IDLE;
          else begin
            ch    <= ch + 1'b1;
            state <= SEQ_REQ;
          end
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  assign req_valid   = (state == SEQ_REQ);
  assign req_ch      = ch;
  assign res_ready   = (state == SEQ_WAIT);
  assign wr_fire     = res_ready && res_valid;
  assign busy        = (state != SEQ_IDLE);
  assign overrun_hit = tick && busy;

  // R2: a stalled request keeps its valid and channel
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_ch)));
  // R2: after a non-final result the next channel is requested
  assert_ch_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && req_ch != LAST_CH) |=> (req_valid && req_ch == $past(req_ch) + 1'b1));
  // R3: result handshake only when awaiting
  assert_res_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && res_ready));
endmodule

// File: rtl/adc_ring_addr.sv
module adc_ring_addr #(
  parameter int unsigned TOTAL = 6400,
  parameter int unsigned PTR_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             park,
  output logic [PTR_W-1:0] ptr,
  output logic             half_hit,
  output logic             full_hit
);
  localparam logic [PTR_W-1:0] HALF_LAST = PTR_W'(TOTAL / 2 - 1);
  localparam logic [PTR_W-1:0] TOT_LAST  = PTR_W'(TOTAL - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ptr <= '0;
    else if (wr)               ptr <= (ptr == TOT_LAST) ? '0 : ptr + 1'b1;
    else if (park)             ptr <= '0;
  end

  assign half_hit = wr && (ptr == HALF_LAST);
  assign full_hit = wr && (ptr == TOT_LAST);

  // R4: pointer stays inside the ring
  assert_ptr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= TOT_LAST);
  // R4: ordinary write advances by one
  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && ptr != TOT_LAST) |=> (ptr == $past(ptr) + 1'b1));
  // R5: the end write wraps
  assert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    full_hit |=> (ptr == '0));
endmodule

// File: rtl/adc_evt_flags.sv
module adc_evt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic half_hit,
  input  logic full_hit,
  input  logic overrun_hit,
  output logic half_flag,
  output logic full_flag,
  output logic lost_flag,
  output logic overrun_flag
);
  logic [1:0] hit;
  logic [1:0] flag;
  logic       lost_set;

  assign hit = {full_hit, half_hit};

  for (genvar g = 0; g < 2; g++) begin : g_blk
    logic f;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      f <= 1'b0;
      else if (hit[g]) f <= 1'b1;
      else if (clr)    f <= 1'b0;
    end
    assign flag[g] = f;

    // R6: a set flag survives until clear
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag[g] && !clr) |=> flag[g]);
    // R6: clear without a new event empties the flag
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !hit[g]) |=> !flag[g]);
  end

  assign lost_set = (|(hit & flag)) && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_flag    <= 1'b0;
      overrun_flag <= 1'b0;
    end else begin
      if (lost_set)      lost_flag <= 1'b1;
      else if (clr)      lost_flag <= 1'b0;
      if (overrun_hit)   overrun_flag <= 1'b1;
      else if (clr)      overrun_flag <= 1'b0;
    end
  end

  assign half_flag = flag[0];
  assign full_flag = flag[1];

  // R7: re-fired event with flag pending marks a lost block
  assert_lost_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (half_hit && half_flag && !clr) |=> lost_flag);
  // R8: tick during a scan is recorded
  assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_hit |=> overrun_flag);
endmodule

// File: rtl/adc_ring_writer.sv
module adc_ring_writer #(
  parameter int unsigned NUM_CH         = 4,
  parameter int unsigned SAMPLES_PER_CH = 1600,
  parameter int unsigned ADC_W          = 12,
  parameter int unsigned WORD_W         = 16,
  parameter int unsigned TICK_DIV       = 4000,
  localparam int unsigned TOTAL         = NUM_CH * SAMPLES_PER_CH,
  localparam int unsigned PTR_W         = $clog2(TOTAL),
  localparam int unsigned CH_W          = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              clear,
  output logic              conv_req_valid,
  input  logic              conv_req_ready,
  output logic [CH_W-1:0]   conv_req_ch,
  input  logic              conv_res_valid,
  output logic              conv_res_ready,
  input  logic [ADC_W-1:0]  conv_res_data,
  output logic              mem_we,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              half_evt,
  output logic              full_evt,
  output logic              half_flag,
  output logic              full_flag,
  output logic              lost_flag,
  output logic              overrun_flag
);
  logic tick, wr_fire, busy, overrun_hit, half_hit, full_hit;

  adc_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(enable), .tick(tick)
  );

  adc_scan_seq #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(conv_req_valid), .req_ready(conv_req_ready), .req_ch(conv_req_ch),
    .res_valid(conv_res_valid), .res_ready(conv_res_ready),
    .wr_fire(wr_fire), .busy(busy), .overrun_hit(overrun_hit)
  );

  adc_ring_addr #(.TOTAL(TOTAL), .PTR_W(PTR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .wr(wr_fire), .park(!enable && !busy),
    .ptr(mem_addr), .half_hit(half_hit), .full_hit(full_hit)
  );

  adc_evt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .clr(clear),
    .half_hit(half_hit), .full_hit(full_hit), .overrun_hit(overrun_hit),
    .half_flag(half_flag), .full_flag(full_flag),
    .lost_flag(lost_flag), .overrun_flag(overrun_flag)
  );

  if (WORD_W > ADC_W) begin : g_zext
    assign mem_wdata = {{(WORD_W - ADC_W){1'b0}}, conv_res_data};
  end else begin : g_trunc
    assign mem_wdata = conv_res_data[WORD_W-1:0];
  end

  assign mem_we   = wr_fire;
  assign half_evt = half_hit;
  assign full_evt = full_hit;

  // R3: writes only happen on a result handshake
  assert_we_handshake_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (conv_res_valid && conv_res_ready));
  // R5: the two events never coincide
  assert_evt_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(half_evt && full_evt));
endmodule

// File: tb/adc_ring_writer_bench.sv
`timescale 1ns/1ps
module adc_ring_writer_bench;
  localparam int NCH = 4;
  localparam int SPC = 4;
  localparam int TD  = 20;
  localparam int TOT = NCH * SPC;
  localparam int HALF = TOT / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic clear = 1'b0;
  logic conv_req_valid, conv_req_ready, conv_res_valid, conv_res_ready;
  logic [1:0] conv_req_ch;
  logic [11:0] conv_res_data;
  logic mem_we, half_evt, full_evt, half_flag, full_flag, lost_flag, overrun_flag;
  logic [3:0] mem_addr;
  logic [15:0] mem_wdata;

  always #5 clk = ~clk;

  adc_ring_writer #(.NUM_CH(NCH), .SAMPLES_PER_CH(SPC), .TICK_DIV(TD)) u_adc_ring_writer (
    .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
    .conv_req_valid(conv_req_valid), .conv_req_ready(conv_req_ready), .conv_req_ch(conv_req_ch),
    .conv_res_valid(conv_res_valid), .conv_res_ready(conv_res_ready), .conv_res_data(conv_res_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .half_evt(half_evt), .full_evt(full_evt), .half_flag(half_flag), .full_flag(full_flag),
    .lost_flag(lost_flag), .overrun_flag(overrun_flag)
  );

  int n_tests = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: state 0 idle, 1 requesting, 2 awaiting
  int m_state = 0, m_ch = 0, m_ptr = 0, m_cnt = 0;
  bit m_hf = 0, m_ff = 0, m_lost = 0, m_ovr = 0;
  // converter model: phase 0 free, 1 converting, 2 presenting
  int cv_phase = 0, cv_lat = 0, cv_wait = 0, cv_val = 0, cv_seq = 0;
  int rdy_dly = 0, res_dly = 0;
  bit auto_clr = 0, man_clr = 0;
  bit watch_first = 0;
  int first_addr = -1;
  int req_seen = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_ch = 0; m_ptr = 0; m_cnt = 0;
      m_hf = 0; m_ff = 0; m_lost = 0; m_ovr = 0;
      cv_phase = 0; cv_lat = 0; cv_wait = 0;
    end else begin
      bit tk, wr, hs, hh, fh;
      tk = enable && (m_cnt == TD - 1);
      wr = (m_state == 2) && conv_res_valid;
      hs = (m_state == 1) && conv_req_ready;
      hh = wr && (m_ptr == HALF - 1);
      fh = wr && (m_ptr == TOT - 1);
      if (((hh && m_hf) || (fh && m_ff)) && !clear) m_lost = 1;
      else if (clear) m_lost = 0;
      if (hh) m_hf = 1; else if (clear) m_hf = 0;
      if (fh) m_ff = 1; else if (clear) m_ff = 0;
      if (tk && m_state != 0) m_ovr = 1; else if (clear) m_ovr = 0;
      // converter
      if (cv_phase == 0) begin
        if (hs) begin
          cv_phase = 1; cv_lat = 0; cv_wait = 0;
          cv_val = (cv_seq * 173 + m_ch * 911 + 5) % 4096;
        end else if (m_state == 1) cv_wait++;
      end else if (cv_phase == 1) begin
        cv_lat++;
        if (cv_lat > res_dly) cv_phase = 2;
      end else if (wr) begin
        cv_phase = 0; cv_seq++;
      end
      // sequencer and pointer
      if (wr) m_ptr = (m_ptr + 1) % TOT;
      else if (!enable && m_state == 0) m_ptr = 0;
      case (m_state)
        0: if (tk) begin m_state = 1; m_ch = 0; end
        1: if (hs) m_state = 2;
        default: if (wr) begin
          if (m_ch == NCH - 1) m_state = 0;
          else begin m_ch++; m_state = 1; end
        end
      endcase
      m_cnt = !enable ? 0 : (m_cnt == TD - 1) ? 0 : m_cnt + 1;
    end
  end

  always @(negedge clk) begin
    bit ewe;
    conv_req_ready = (cv_phase == 0) && (cv_wait >= rdy_dly);
    conv_res_valid = (cv_phase == 2);
    conv_res_data  = cv_val[11:0];
    clear = man_clr || (auto_clr && (m_hf || m_ff));
    #1;
    ewe = (m_state == 2) && conv_res_valid;
    chk(conv_req_valid == (m_state == 1), "R1 req_valid", conv_req_valid, m_state == 1);
    if (m_state == 1) chk(conv_req_ch == m_ch, "R2 req_ch", conv_req_ch, m_ch);
    chk(conv_res_ready == (m_state == 2), "R3 res_ready", conv_res_ready, m_state == 2);
    chk(mem_we == ewe, "R3 mem_we", mem_we, ewe);
    if (ewe) begin
      chk(mem_addr == m_ptr, "R4 mem_addr", mem_addr, m_ptr);
      chk(mem_wdata == cv_val, "R3 mem_wdata", mem_wdata, cv_val);
    end
    chk(half_evt == (ewe && m_ptr == HALF - 1), "R5 half_evt", half_evt, ewe && m_ptr == HALF - 1);
    chk(full_evt == (ewe && m_ptr == TOT - 1), "R5 full_evt", full_evt, ewe && m_ptr == TOT - 1);
    chk(half_flag == m_hf, "R6 half_flag", half_flag, m_hf);
    chk(full_flag == m_ff, "R6 full_flag", full_flag, m_ff);
    chk(lost_flag == m_lost, "R7 lost_flag", lost_flag, m_lost);
    chk(overrun_flag == m_ovr, "R8 overrun_flag", overrun_flag, m_ovr);
    if (watch_first && mem_we) begin first_addr = mem_addr; watch_first = 0; end
    if (conv_req_valid) req_seen++;
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 100000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    step(3);
    // R10: reset state
    chk(!conv_req_valid && !mem_we && !half_flag && !full_flag && !lost_flag && !overrun_flag,
        "R10 reset outputs", int'(conv_req_valid | mem_we | half_flag | lost_flag), 0);
    rst_n = 1'b1;
    step(2);
    enable = 1'b1;
    step(350);
    // R7: never cleared, so several wraps lose blocks
    chk(lost_flag == 1'b1, "R7 lost after unacked wraps", lost_flag, 1);
    man_clr = 1'b1; step(1); man_clr = 1'b0; step(1);
    chk(lost_flag == 1'b0, "R6 clear empties lost", lost_flag, 0);
    auto_clr = 1'b1; rdy_dly = 1;
    step(600);
    chk(lost_flag == 1'b0, "R7 no loss with prompt clear", lost_flag, 0);
    chk(overrun_flag == 1'b0, "R8 no overrun when scan fits", overrun_flag, 0);
    auto_clr = 1'b0; rdy_dly = 0; res_dly = 6;
    step(200);
    chk(overrun_flag == 1'b1, "R8 overrun with slow converter", overrun_flag, 1);
    man_clr = 1'b1; step(1); man_clr = 1'b0;
    res_dly = 0;
    step(37);
    enable = 1'b0;
    step(30);
    req_seen = 0;
    step(60);
    chk(req_seen == 0, "R9 no scan while disabled", req_seen, 0);
    watch_first = 1'b1;
    enable = 1'b1;
    step(100);
    chk(first_addr == 0, "R9 restart at entry 0", first_addr, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule